// File: doc/BRIEF.md
# Cycle-Stealing DMA Load Controller

This block lets an external byte-wide device move data to or from memory without stopping the processor core. It takes the memory bus only in machine cycles that the core has said it will not use. A machine cycle is a fixed number of clocks, eight by default. The block makes its grant decision on the last clock of a machine cycle, so every transfer fills one whole machine cycle.

The address comes from a single 16-bit pointer. This is the core's general register, which the core can also write. Each completed transfer advances the pointer by one. A device therefore walks through consecutive memory just by requesting again. There is no byte count and no descriptor.

Two active-low request lines select the direction:
- device-to-memory ("in"), which writes memory;
- memory-to-device ("out"), which reads memory and hands the byte to the device.

When the host holds both its clear and its wait controls high, the block is in load mode. In load mode it serves requests even though the core is frozen. Memory can then be filled from switches or a keypad with no boot program: set a byte, pulse the in request, and the address moves on by itself.

Top module: `dma_cycle_steal`

## Requirements
- R1: After reset, `cur_ptr` is 0x0000, `mc_phase` is 0, and `dma_busy`, `mem_rd`, `mem_wr` and `dev_stb` are all low.
- R2: `mc_phase` counts 0 to MC_LEN-1 and wraps. A grant is decided on the clock where `mc_phase` is MC_LEN-1. `dma_busy` rises only with `mc_phase` equal to 0 and stays high for exactly MC_LEN clocks per granted transfer.
- R3: An in transfer works as follows:
   - `mem_addr` equals the pointer for the whole cycle.
   - `mem_wdata` equals `dev_wdata`.
   - `mem_wr` is high exactly while `mc_phase` is in STB_FIRST..STB_LAST (3..5 by default).
   - `mem_rd` stays low.
- R4: An out transfer works as follows:
   - `mem_rd` is high for the whole machine cycle and `mem_wr` stays low.
   - `dev_rdata` takes `mem_rdata` as sampled on the clock where `mc_phase` is STB_LAST.
   - `dev_stb` is high for the single following clock, where `mc_phase` is STB_LAST+1.
- R5: After each granted transfer the pointer increases by one, so successive transfers address consecutive locations.
- R6: The pointer wraps from 0xFFFF to 0x0000.
- R7: If both requests are pending at the same decision point, the in request is granted first (IN_FIRST=1).
- R8: If `core_bus_req` is high at a decision point outside load mode, no grant is made. A request still pending is served at the next decision point where the core does not claim the bus.
- R9: While `host_clear` is high and `host_wait` is low:
   - the pointer is forced to 0x0000;
   - no transfer is granted;
   - a transfer in progress is dropped on the next clock.
- R10: With both `host_clear` and `host_wait` high, `load_mode` is high and the pointer keeps its value. In requests are served whatever `core_bus_req` says, and each one writes at the pointer and advances it.
- R11: A request held low is served once per machine cycle, with grant starts exactly MC_LEN clocks apart.
- R12: A `core_ptr_we` pulse loads `core_ptr_wdata` into the pointer on the next clock. `cur_ptr` always shows the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_clear | input | 1 | Host clear control, active high |
| host_wait | input | 1 | Host wait control, active high |
| core_bus_req | input | 1 | Core claims memory in the next machine cycle (sampled at phase MC_LEN-1) |
| core_ptr_we | input | 1 | Core writes the pointer register |
| core_ptr_wdata | input | ADDR_W | Value written into the pointer |
| cur_ptr | output | ADDR_W | Current pointer value |
| dma_in_n | input | 1 | Device-to-memory request, active low |
| dma_out_n | input | 1 | Memory-to-device request, active low |
| dev_wdata | input | DATA_W | Byte from the device |
| dev_rdata | output | DATA_W | Byte read for the device |
| dev_stb | output | 1 | One-clock pulse: `dev_rdata` is valid |
| mem_addr | output | ADDR_W | Memory address, pointer during a grant, zero otherwise |
| mem_rd | output | 1 | Memory read enable |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| dma_busy | output | 1 | A granted transfer owns this machine cycle |
| load_mode | output | 1 | Clear and wait both high |
| mc_phase | output | $clog2(MC_LEN) | Clock position inside the machine cycle |

## Verification
Requests pass a SYNC_STAGES synchronizer and are decided at phase MC_LEN-1. A request is therefore seen as `dma_busy` with `mc_phase` 0 at the start of the next machine cycle at the earliest.

The bench's scoreboard monitor samples on falling edges:
- It pops one expected transfer at each phase-0 grant start and compares the direction and address there.
- It compares write data at phase STB_FIRST, counts the write-strobe clocks against STB_LAST-STB_FIRST+1, and checks the read byte when `dev_stb` shows at phase STB_LAST+1.

Pointer values are checked after `dma_busy` falls, one clock after the increment edge. The driver releases a request on the falling edge where it sees the grant start. The synchronizer delay then still clears the request before the next decision point, so each pulse yields exactly one transfer.

// File: rtl/dma_cs_pkg.sv
package dma_cs_pkg;
   typedef enum logic {
      XFER_OUT = 1'b0,
      XFER_IN  = 1'b1
   } xfer_dir_e;
endpackage

// File: rtl/dma_cs_sync.sv
module dma_cs_sync #(
   parameter int WIDTH = 2,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] chain [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
         end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         end
      end
      assign q = chain[STAGES-1];
   end
endmodule

// File: rtl/dma_cs_phase.sv
module dma_cs_phase #(
   parameter int MC_LEN = 8,
   localparam int PH_W = $clog2(MC_LEN)
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [PH_W-1:0] phase,
   output logic            mc_last
);
   localparam logic [PH_W-1:0] LAST = PH_W'(MC_LEN - 1);

   assign mc_last = (phase == LAST);

   if (MC_LEN == (1 << PH_W)) begin : g_pow2
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) phase <= '0;
         else        phase <= phase + 1'b1;
      end
   end else begin : g_modulo
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       phase <= '0;
         else if (mc_last) phase <= '0;
         else              phase <= phase + 1'b1;
      end
   end

   // R2: the cycle wraps back to phase 0 after its last clock
   a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      mc_last |=> (phase == '0));
endmodule

// File: rtl/dma_cs_arbiter.sv
module dma_cs_arbiter
   import dma_cs_pkg::*;
#(
   parameter bit IN_FIRST = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mc_last,
   input  logic      req_in,
   input  logic      req_out,
   input  logic      core_bus_req,
   input  logic      load_mode,
   input  logic      clear_only,
   output logic      busy,
   output xfer_dir_e dir
);
   logic      allowed;
   logic      any_req;
   xfer_dir_e pick;

   assign allowed = load_mode || !core_bus_req;
   assign any_req = req_in || req_out;

   if (IN_FIRST) begin : g_in_first
      assign pick = req_in ? XFER_IN : XFER_OUT;
   end else begin : g_out_first
      assign pick = req_out ? XFER_OUT : XFER_IN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         dir  <= XFER_OUT;
      end else if (clear_only) begin
         busy <= 1'b0;
      end else if (mc_last) begin
         busy <= allowed && any_req;
         if (allowed && any_req) dir <= pick;
      end
   end

   // R2: a grant only begins right after a decision point
   a_r2_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(mc_last));
   // R2: a grant is held until the machine cycle ends
   a_r2_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mc_last && !clear_only) |=> busy);
   // R8: a core claim outside load mode blocks the grant
   a_r8_core_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_last && core_bus_req && !load_mode) |=> !busy);
   // R9: clear without wait stops any transfer
   a_r9_clear_stops: assert property (@(posedge clk) disable iff (!rst_n)
      clear_only |=> !busy);
   if (IN_FIRST) begin : g_prio_chk
      // R7: the in request wins a tie
      a_r7_in_wins: assert property (@(posedge clk) disable iff (!rst_n)
         (mc_last && req_in && req_out && allowed && !clear_only) |=> (busy && dir == XFER_IN));
   end
endmodule

// File: rtl/dma_cs_ptr.sv
module dma_cs_ptr #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_only,
   input  logic              core_we,
   input  logic [ADDR_W-1:0] core_wdata,
   input  logic              step,
   output logic [ADDR_W-1:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ptr <= '0;
      else if (clear_only) ptr <= '0;
      else if (core_we)    ptr <= core_wdata;
      else if (step)       ptr <= ptr + 1'b1;
   end

   // R5/R6: a completed transfer moves the pointer on by one, wrapping at the top
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clear_only && !core_we) |=> (ptr == $past(ptr) + 1'b1));
   // R9: clear without wait zeroes the pointer
   a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clear_only |=> (ptr == '0));
   // R12: a core write lands on the next clock
   a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
      (core_we && !clear_only) |=> (ptr == $past(core_wdata)));
endmodule

// File: rtl/dma_cycle_steal.sv
module dma_cycle_steal
   import dma_cs_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int MC_LEN      = 8,
   parameter int STB_FIRST   = 3,
   parameter int STB_LAST    = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit IN_FIRST    = 1'b1,
   localparam int PH_W = $clog2(MC_LEN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_clear,
   input  logic              host_wait,
   input  logic              core_bus_req,
   input  logic              core_ptr_we,
   input  logic [ADDR_W-1:0] core_ptr_wdata,
   output logic [ADDR_W-1:0] cur_ptr,
   input  logic              dma_in_n,
   input  logic              dma_out_n,
   input  logic [DATA_W-1:0] dev_wdata,
   output logic [DATA_W-1:0] dev_rdata,
   output logic              dev_stb,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              dma_busy,
   output logic              load_mode,
   output logic [PH_W-1:0]   mc_phase
);
   localparam logic [PH_W-1:0] PH_STB_FIRST = PH_W'(STB_FIRST);
   localparam logic [PH_W-1:0] PH_STB_LAST  = PH_W'(STB_LAST);

   if (MC_LEN < 4) begin : g_bad_len
      $error("MC_LEN must be at least 4");
   end
   if (STB_FIRST < 1 || STB_FIRST > STB_LAST) begin : g_bad_win
      $error("strobe window must satisfy 1 <= STB_FIRST <= STB_LAST");
   end
   if (STB_LAST > MC_LEN - 2) begin : g_bad_last
      $error("STB_LAST must leave one clock for the device strobe");
   end
   if (ADDR_W < 2 || DATA_W < 1 || SYNC_STAGES < 0) begin : g_bad_width
      $error("illegal width or synchronizer depth");
   end

   logic      clear_only;
   logic      mc_last;
   logic      req_in;
   logic      req_out;
   logic      in_win;
   logic      rd_capture;
   logic [1:0] req_n_sync;
   xfer_dir_e dir;

   assign load_mode  = host_clear && host_wait;
   assign clear_only = host_clear && !host_wait;

   dma_cs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dma_in_n, dma_out_n}),
      .q     (req_n_sync)
   );
   assign req_in  = !req_n_sync[1];
   assign req_out = !req_n_sync[0];

   dma_cs_phase #(.MC_LEN(MC_LEN)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .phase   (mc_phase),
      .mc_last (mc_last)
   );

   dma_cs_arbiter #(.IN_FIRST(IN_FIRST)) u_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .mc_last      (mc_last),
      .req_in       (req_in),
      .req_out      (req_out),
      .core_bus_req (core_bus_req),
      .load_mode    (load_mode),
      .clear_only   (clear_only),
      .busy         (dma_busy),
      .dir          (dir)
   );

   dma_cs_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_only (clear_only),
      .core_we    (core_ptr_we),
      .core_wdata (core_ptr_wdata),
      .step       (dma_busy && mc_last),
      .ptr        (cur_ptr)
   );

   assign in_win     = (mc_phase >= PH_STB_FIRST) && (mc_phase <= PH_STB_LAST);
   assign mem_addr   = dma_busy ? cur_ptr : '0;
   assign mem_rd     = dma_busy && (dir == XFER_OUT);
   assign mem_wr     = dma_busy && (dir == XFER_IN) && in_win;
   assign mem_wdata  = (dma_busy && dir == XFER_IN) ? dev_wdata : '0;
   assign rd_capture = mem_rd && (mc_phase == PH_STB_LAST) && !clear_only;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_rdata <= '0;
         dev_stb   <= 1'b0;
      end else begin
         dev_stb <= rd_capture;
         if (rd_capture) dev_rdata <= mem_rdata;
      end
   end

   // R3: writes happen only inside a granted in transfer
   a_r3_wr_in_grant: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (dma_busy && dir == XFER_IN));
   // R4: read and write never overlap
   a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   // R4: the device strobe lasts a single clock
   a_r4_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      dev_stb |=> !dev_stb);
endmodule

// File: tb/test_dma_cycle_steal.sv
`timescale 1ns/1ps
module test_dma_cycle_steal;
   localparam int MC_LEN    = 8;
   localparam int STB_FIRST = 3;
   localparam int STB_LAST  = 5;

   typedef struct {
      bit          is_in;
      logic [15:0] addr;
      logic [7:0]  data;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_clear = 1'b0, host_wait = 1'b0, core_bus_req = 1'b0;
   logic        core_ptr_we = 1'b0;
   logic [15:0] core_ptr_wdata = '0;
   logic [15:0] cur_ptr;
   logic        dma_in_n = 1'b1, dma_out_n = 1'b1;
   logic [7:0]  dev_wdata = '0;
   logic [7:0]  dev_rdata;
   logic        dev_stb;
   logic [15:0] mem_addr;
   logic        mem_rd, mem_wr;
   logic [7:0]  mem_wdata, mem_rdata;
   logic        dma_busy, load_mode;
   logic [2:0]  mc_phase;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   longint cyc = 0;
   item_t exp_q[$];
   item_t cur;
   logic [15:0] exp_ptr = '0;
   bit    prev_busy = 1'b0;
   int    wr_cnt = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] mem_fn(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction
   assign mem_rdata = mem_fn(mem_addr);

   dma_cycle_steal i_dma_cycle_steal (
      .clk(clk), .rst_n(rst_n), .host_clear(host_clear), .host_wait(host_wait),
      .core_bus_req(core_bus_req), .core_ptr_we(core_ptr_we), .core_ptr_wdata(core_ptr_wdata),
      .cur_ptr(cur_ptr), .dma_in_n(dma_in_n), .dma_out_n(dma_out_n), .dev_wdata(dev_wdata),
      .dev_rdata(dev_rdata), .dev_stb(dev_stb), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dma_busy(dma_busy),
      .load_mode(load_mode), .mc_phase(mc_phase)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic push(input bit is_in, input logic [7:0] d);
      item_t it;
      it.is_in = is_in;
      it.addr  = exp_ptr;
      it.data  = d;
      exp_q.push_back(it);
      exp_ptr = exp_ptr + 16'd1;
   endtask

   task automatic wait_start();
      @(negedge clk);
      while (!(dma_busy && mc_phase == 3'd0)) @(negedge clk);
   endtask

   task automatic wait_idle();
      while (dma_busy) @(negedge clk);
   endtask

   task automatic xfer_in(input logic [7:0] d);
      dev_wdata = d;
      push(1'b1, d);
      dma_in_n = 1'b0;
      wait_start();
      dma_in_n = 1'b1;
      wait_idle();
   endtask

   task automatic xfer_out();
      push(1'b0, 8'h00);
      dma_out_n = 1'b0;
      wait_start();
      dma_out_n = 1'b1;
      wait_idle();
   endtask

   task automatic write_ptr(input logic [15:0] v);
      core_ptr_wdata = v;
      core_ptr_we = 1'b1;
      @(negedge clk);
      core_ptr_we = 1'b0;
      exp_ptr = v;
      chk(cur_ptr == v, "R12 pointer write", cur_ptr, v);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (dma_busy && !prev_busy && mc_phase != 3'd0)
            chk(1'b0, "R2 grant off boundary", mc_phase, 0);
         if (dma_busy && mc_phase == 3'd0) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 unexpected grant", mem_addr, 0);
            end else begin
               cur = exp_q.pop_front();
               wr_cnt = 0;
               chk(mem_rd == !cur.is_in, "R7 transfer direction", mem_rd, !cur.is_in);
               chk(mem_addr == cur.addr, "R5 transfer address", mem_addr, cur.addr);
            end
         end
         if (mem_wr) begin
            wr_cnt++;
            if (mc_phase == 3'(STB_FIRST))
               chk(mem_wdata == cur.data, "R3 write data", mem_wdata, cur.data);
         end
         if (dma_busy && mc_phase == 3'(MC_LEN-1) && cur.is_in)
            chk(wr_cnt == STB_LAST-STB_FIRST+1, "R3 write strobe width", wr_cnt, STB_LAST-STB_FIRST+1);
         if (dev_stb)
            chk(dev_rdata == mem_fn(cur.addr) && mc_phase == 3'(STB_LAST+1),
                "R4 read byte to device", dev_rdata, mem_fn(cur.addr));
         prev_busy = dma_busy;
      end
   end

   // watchdog
   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      longint t0, t1, t2;
      bit seen;
      repeat (5) @(negedge clk);
      chk(cur_ptr == 16'h0 && mc_phase == 3'd0, "R1 reset pointer/phase", cur_ptr, 0);
      chk(!dma_busy && !mem_rd && !mem_wr && !dev_stb, "R1 reset strobes",
          {dma_busy, mem_rd, mem_wr, dev_stb}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3/R5: consecutive in transfers
      xfer_in(8'h3C);
      xfer_in(8'hC3);
      xfer_in(8'h00);
      chk(cur_ptr == 16'd3, "R5 pointer after three transfers", cur_ptr, 3);

      // R4: out transfers
      xfer_out();
      xfer_out();
      chk(cur_ptr == 16'd5, "R4 pointer after out transfers", cur_ptr, 5);

      // R7: both pending, in first then out
      push(1'b1, 8'h81);
      push(1'b0, 8'h00);
      dev_wdata = 8'h81;
      dma_in_n = 1'b0;
      dma_out_n = 1'b0;
      wait_start();
      dma_in_n = 1'b1;
      wait_start();
      dma_out_n = 1'b1;
      wait_idle();
      chk(cur_ptr == 16'd7, "R7 pointer after tie", cur_ptr, 7);

      // R8: core claim blocks grants
      core_bus_req = 1'b1;
      dev_wdata = 8'h5E;
      push(1'b1, 8'h5E);
      dma_in_n = 1'b0;
      seen = 1'b0;
      repeat (3*MC_LEN) begin
         @(negedge clk);
         if (dma_busy) seen = 1'b1;
      end
      chk(!seen, "R8 no grant while core claims bus", seen, 0);
      core_bus_req = 1'b0;
      wait_start();
      dma_in_n = 1'b1;
      wait_idle();
      chk(cur_ptr == 16'd8, "R8 deferred transfer served", cur_ptr, 8);

      // R11: held request, back-to-back grants
      dev_wdata = 8'h77;
      push(1'b1, 8'h77);
      push(1'b1, 8'h77);
      push(1'b1, 8'h77);
      dma_in_n = 1'b0;
      wait_start(); t0 = cyc;
      wait_start(); t1 = cyc;
      wait_start(); t2 = cyc;
      dma_in_n = 1'b1;
      wait_idle();
      chk((t1 - t0) == MC_LEN && (t2 - t1) == MC_LEN, "R11 grant spacing", t1 - t0, MC_LEN);
      chk(cur_ptr == 16'd11, "R11 pointer after burst", cur_ptr, 11);

      // R6: wrap
      write_ptr(16'hFFFE);
      xfer_in(8'hE1);
      xfer_in(8'hE2);
      chk(cur_ptr == 16'h0000, "R6 pointer wrap", cur_ptr, 0);

      // R9: clear without wait
      write_ptr(16'h0040);
      host_clear = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(cur_ptr == 16'h0 && !load_mode, "R9 clear zeroes pointer", cur_ptr, 0);
      dma_in_n = 1'b0;
      seen = 1'b0;
      repeat (2*MC_LEN) begin
         @(negedge clk);
         if (dma_busy) seen = 1'b1;
      end
      chk(!seen, "R9 no grant during clear", seen, 0);
      dma_in_n = 1'b1;
      repeat (4) @(negedge clk);
      host_clear = 1'b0;
      exp_ptr = 16'h0;
      xfer_in(8'h9A);
      chk(cur_ptr == 16'h1, "R9 ignored request left pointer", cur_ptr, 1);

      // R10: load mode
      write_ptr(16'h1230);
      host_clear = 1'b1;
      host_wait = 1'b1;
      core_bus_req = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(load_mode && cur_ptr == 16'h1230, "R10 load mode keeps pointer", cur_ptr, 16'h1230);
      xfer_in(8'h11);
      xfer_in(8'h22);
      xfer_in(8'h33);
      chk(cur_ptr == 16'h1233, "R10 load mode fill", cur_ptr, 16'h1233);
      host_clear = 1'b0;
      host_wait = 1'b0;
      core_bus_req = 1'b0;

      repeat (20) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all expected transfers seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule